// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the serial front end of a byte-addressed nonvolatile memory. It watches the four incoming SPI wires (serial clock, active-low select, serial data in, active-low pause), oversamples them in the system clock domain and decodes one 8-bit command per selection. Commands read the array sequentially, read or write the status byte held by a companion protection unit, set or clear the write-enable latch in that unit, or stream bytes to a page-write sequencer. The block drives the serial data output together with an output-enable, so the pad can tri-state when the enable is low.

The array sits outside the block behind a synchronous read port: the block presents an address and uses the data that comes back one system clock later. The block does not judge whether a write is allowed. It passes each complete data byte with its in-page address to the sequencer, and it signals a commit when the host deselects on a byte boundary. Serial clock polarity modes 0 and 3 both work: input bits are taken on rising serial clock edges and output bits change on falling ones.

Top module: `spi_mem_slave`

## Requirements
- R1: The first byte after select is the command, received MSB first. The upper nibble must be 0000 and bit 3 is ignored. The low three bits select the command: 110 sets write enable, 100 clears it, 101 reads status, 001 writes status, 011 reads the array, 010 writes the array.
- R2: A read takes a 16-bit address (MSB first) after the command, then sends array bytes MSB first on `so`. The address advances by one after each byte.
- R3: The read address wraps from 0xFFFF to 0x0000, and the stream continues.
- R4: After an unknown command, `so_oe` stays low and no command output pulses until `cs_n` falls again. The next selection is decoded normally.
- R5: While `busy` is high when the command byte completes, every command except status read is dropped: no pulses and no output enable.
- R6: With `hold_n` low, taken while the serial clock is low, `so_oe` is low and clock edges are ignored. Releasing it resumes the transfer with no bit lost.
- R7: While deselected, `so_oe` is low. Raising `cs_n` part way through a byte cancels that byte with no pulse.
- R8: Each set or clear command gives one `wren_set` or `wren_clr` pulse. At most one of the command pulses is high in any cycle.
- R9: A status read shifts `status_in` out MSB first, repeating it for every further byte.
- R10: A status write takes one data byte, pulses `status_wr` once with that byte on `status_wdata`, and ignores the bytes that follow.
- R11: An array write passes each complete data byte with `wr_byte_valid`, `wr_addr` and `wr_data`. Between bytes only the low 7 address bits advance, wrapping inside the 128-byte page.
- R12: `wr_commit` pulses once when `cs_n` rises on a byte boundary after at least one write data byte. It does not pulse after a partial byte.
- R13: Both serial clock idle levels (modes 0 and 3) give the same results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Active-low transfer pause |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |
| busy | input | 1 | Internal write cycle in progress |
| mem_addr | output | 16 | Array read address |
| mem_rdata | input | 8 | Array read data, one clock after `mem_addr` |
| status_in | input | 8 | Status byte from the protection unit |
| wren_set | output | 1 | Pulse: set write-enable latch |
| wren_clr | output | 1 | Pulse: clear write-enable latch |
| status_wr | output | 1 | Pulse: write status byte |
| status_wdata | output | 8 | Status byte to write |
| wr_byte_valid | output | 1 | Pulse: one write data byte is ready |
| wr_addr | output | 16 | Address of that byte |
| wr_data | output | 8 | The write data byte |
| wr_commit | output | 1 | Pulse: start the page program |

## Verification
The bench reads across the top of the address space. A design without the wrap would return the byte at 0x10000's truncation wrong or stop. It writes across a page end: an address counter that carries into bit 7 would log 0x1280 instead of 0x1200. It pauses a read in the middle of a byte and toggles the clock during the pause. A pause that is not honoured would drop or repeat bits, and the byte would come back shifted. It also aborts commands part way through a byte, sends an unknown command followed by a valid one, and issues commands while busy. A design that acts too early or fails to lock out would show extra set, commit or byte pulses, or drive the output.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_RDAT, ST_SOUT, ST_WDAT, ST_SWR, ST_LOCK
  } st_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_WREN, OP_WRDI, OP_RDSR, OP_WRSR, OP_READ, OP_WRITE
  } op_t;

  // Upper nibble must be zero, bit 3 is don't-care, low three bits pick the command.
  function automatic op_t decode_op(input logic [7:0] b);
    op_t r;
    if (b[7:4] != 4'h0) r = OP_NONE;
    else begin
      case (b[2:0])
        3'b110:  r = OP_WREN;
        3'b100:  r = OP_WRDI;
        3'b101:  r = OP_RDSR;
        3'b001:  r = OP_WRSR;
        3'b011:  r = OP_READ;
        3'b010:  r = OP_WRITE;
        default: r = OP_NONE;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else if (g == 0) stg[g] <= d;
        else stg[g] <= stg[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_mem_edge.sv
module spi_mem_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic csn_s,
  input  logic holdn_s,
  output logic sel,
  output logic hold_on,
  output logic cs_fall,
  output logic cs_rise,
  output logic rise_en,
  output logic fall_en
);
  logic sck_q, csn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      csn_q   <= 1'b1;
      hold_on <= 1'b0;
    end else begin
      sck_q <= sck_s;
      csn_q <= csn_s;
      // pause state may only change while the serial clock is low
      if (csn_s) hold_on <= 1'b0;
      else if (!sck_s) hold_on <= ~holdn_s;
    end
  end

  assign sel     = ~csn_s;
  assign cs_fall = ~csn_s & csn_q;
  assign cs_rise = csn_s & ~csn_q;
  assign rise_en = sel & ~hold_on & sck_s & ~sck_q;
  assign fall_en = sel & ~hold_on & ~sck_s & sck_q;
endmodule

// File: rtl/spi_mem_cmd.sv
module spi_mem_cmd
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_BITS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              hold_on,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              rise_en,
  input  logic              fall_en,
  input  logic              si_s,
  input  logic              busy,
  input  logic [7:0]        mem_rdata,
  input  logic [7:0]        status_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              so_bit,
  output logic              so_drive,
  output logic              wren_set,
  output logic              wren_clr,
  output logic              status_wr,
  output logic [7:0]        status_wdata,
  output logic              wr_byte_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit,
  output logic [2:0]        bitcnt,
  output logic              opc_busy
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int AB_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  // next write address: only the in-page bits advance
  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] m;
    m = {{(ADDR_W-PAGE_BITS){1'b0}}, {PAGE_BITS{1'b1}}};
    return (a & ~m) | ((a + ADDR_W'(1)) & m);
  endfunction

  st_t              st;
  logic [6:0]       shin;
  logic [6:0]       shout;
  logic [2:0]       outcnt;
  logic [AB_W-1:0]  acnt;
  logic [ADDR_W-1:0] addr;
  logic             is_wr, wr_any;
  logic [7:0]       byte_in, src;
  logic             in_phase, talking, byte_done;
  op_t              op_now;

  always_comb begin
    byte_in   = {shin, si_s};
    op_now    = decode_op(byte_in);
    in_phase  = (st == ST_OPC) || (st == ST_ADDR) || (st == ST_WDAT) || (st == ST_SWR);
    talking   = (st == ST_RDAT) || (st == ST_SOUT);
    byte_done = rise_en && in_phase && (bitcnt == 3'd7);
    src       = (st == ST_RDAT) ? mem_rdata : status_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; shin <= '0; shout <= '0; outcnt <= '0; acnt <= '0;
      addr <= '0; is_wr <= 1'b0; wr_any <= 1'b0; bitcnt <= '0; opc_busy <= 1'b0;
      so_bit <= 1'b0; wren_set <= 1'b0; wren_clr <= 1'b0; status_wr <= 1'b0;
      status_wdata <= '0; wr_byte_valid <= 1'b0; wr_addr <= '0; wr_data <= '0;
      wr_commit <= 1'b0;
    end else begin
      wren_set <= 1'b0; wren_clr <= 1'b0; status_wr <= 1'b0;
      wr_byte_valid <= 1'b0; wr_commit <= 1'b0;
      if (cs_rise) begin
        if (st == ST_WDAT && bitcnt == 3'd0 && wr_any) wr_commit <= 1'b1;
        st <= ST_IDLE;
      end else if (cs_fall) begin
        st <= ST_OPC; bitcnt <= '0; outcnt <= '0; acnt <= '0;
        so_bit <= 1'b0; wr_any <= 1'b0; opc_busy <= 1'b0;
      end else begin
        if (rise_en && in_phase) begin
          shin   <= byte_in[6:0];
          bitcnt <= bitcnt + 3'd1;
        end
        if (byte_done) begin
          case (st)
            ST_OPC: begin
              opc_busy <= busy;
              if (busy && op_now != OP_RDSR) st <= ST_LOCK;
              else begin
                case (op_now)
                  OP_WREN:  begin wren_set <= 1'b1; st <= ST_LOCK; end
                  OP_WRDI:  begin wren_clr <= 1'b1; st <= ST_LOCK; end
                  OP_RDSR:  st <= ST_SOUT;
                  OP_WRSR:  st <= ST_SWR;
                  OP_READ:  begin is_wr <= 1'b0; st <= ST_ADDR; end
                  OP_WRITE: begin is_wr <= 1'b1; st <= ST_ADDR; end
                  default:  st <= ST_LOCK;
                endcase
              end
            end
            ST_ADDR: begin
              addr <= {addr[ADDR_W-9:0], byte_in};
              if (acnt == AB_W'(ADDR_BYTES - 1)) st <= is_wr ? ST_WDAT : ST_RDAT;
              else acnt <= acnt + AB_W'(1);
            end
            ST_WDAT: begin
              wr_byte_valid <= 1'b1;
              wr_addr       <= addr;
              wr_data       <= byte_in;
              addr          <= page_next(addr);
              wr_any        <= 1'b1;
            end
            ST_SWR: begin
              status_wr    <= 1'b1;
              status_wdata <= byte_in;
              st           <= ST_LOCK;
            end
            default: ;
          endcase
        end
        if (fall_en && talking) begin
          if (outcnt == 3'd0) begin
            so_bit <= src[7];
            shout  <= src[6:0];
            if (st == ST_RDAT) addr <= addr + ADDR_W'(1);
          end else begin
            so_bit <= shout[6];
            shout  <= {shout[5:0], 1'b0};
          end
          outcnt <= outcnt + 3'd1;
        end
      end
    end
  end

  assign mem_addr = addr;
  assign so_drive = sel & ~hold_on & talking;
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int ADDR_W = 16,
  parameter int PAGE_BITS = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic              hold_n,
  output logic              so,
  output logic              so_oe,
  input  logic              busy,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  input  logic [7:0]        status_in,
  output logic              wren_set,
  output logic              wren_clr,
  output logic              status_wr,
  output logic [7:0]        status_wdata,
  output logic              wr_byte_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit
);
  logic [3:0] pins_s;
  logic sel, hold_on, cs_fall, cs_rise, rise_en, fall_en;
  logic [2:0] bitcnt;
  logic opc_busy;

  // order: select, pause, clock, data; select and pause idle high
  spi_mem_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, hold_n, sck, si}), .q(pins_s)
  );

  spi_mem_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sck_s(pins_s[1]), .csn_s(pins_s[3]),
    .holdn_s(pins_s[2]), .sel(sel), .hold_on(hold_on), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .rise_en(rise_en), .fall_en(fall_en)
  );

  spi_mem_cmd #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_cmd (
    .clk(clk), .rst_n(rst_n), .sel(sel), .hold_on(hold_on), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .rise_en(rise_en), .fall_en(fall_en), .si_s(pins_s[0]),
    .busy(busy), .mem_rdata(mem_rdata), .status_in(status_in),
    .mem_addr(mem_addr), .so_bit(so), .so_drive(so_oe),
    .wren_set(wren_set), .wren_clr(wren_clr), .status_wr(status_wr),
    .status_wdata(status_wdata), .wr_byte_valid(wr_byte_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit),
    .bitcnt(bitcnt), .opc_busy(opc_busy)
  );
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       so_oe,
  input logic       sel,
  input logic       hold_on,
  input logic       cs_rise,
  input logic       opc_busy,
  input logic       wren_set,
  input logic       wren_clr,
  input logic       status_wr,
  input logic       wr_byte_valid,
  input logic       wr_commit,
  input logic [2:0] bitcnt
);
  // R7
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !so_oe);

  // R12
  commit_after_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> !sel);

  // R5
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opc_busy |-> !(wren_set || wren_clr || status_wr || wr_byte_valid));

  // R8
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wren_set, wren_clr, status_wr, wr_commit}));

  // R6
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_on && $past(hold_on)) |-> $stable(bitcnt));

  // R6
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_on |-> !so_oe);
endmodule

bind spi_mem_slave spi_mem_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .so_oe(so_oe), .sel(sel), .hold_on(hold_on),
  .cs_rise(cs_rise), .opc_busy(opc_busy), .wren_set(wren_set),
  .wren_clr(wren_clr), .status_wr(status_wr), .wr_byte_valid(wr_byte_valid),
  .wr_commit(wr_commit), .bitcnt(bitcnt)
);

// File: tb/spi_mem_slave_tb.sv
module spi_mem_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8 * CLK_PERIOD;
  localparam int NV = 6;

  typedef struct packed {
    logic        m3;
    logic [7:0]  op;
    logic [15:0] a;
  } vec_t;

  localparam vec_t VT [NV] = '{
    '{1'b0, 8'h03, 16'h0000},
    '{1'b1, 8'h03, 16'h1234},
    '{1'b0, 8'h0B, 16'h7F80},
    '{1'b1, 8'h0B, 16'hFFFE},
    '{1'b0, 8'h03, 16'hFFFF},
    '{1'b1, 8'h03, 16'h8001}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, busy = 1'b0;
  logic so, so_oe, wren_set, wren_clr, status_wr, wr_byte_valid, wr_commit;
  logic [15:0] mem_addr, wr_addr;
  logic [7:0] mem_rdata = 8'h00, status_in = 8'h00, status_wdata, wr_data;

  int n_chk = 0, n_fail = 0, n_set = 0, n_clr = 0, n_swr = 0, n_wb = 0, n_cmt = 0;
  logic oe_seen = 1'b0, m3 = 1'b0, done = 1'b0;
  logic [15:0] log_a [8];
  logic [7:0]  log_d [8];

  spi_mem_slave dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .busy(busy), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .status_in(status_in), .wren_set(wren_set), .wren_clr(wren_clr),
    .status_wr(status_wr), .status_wdata(status_wdata), .wr_byte_valid(wr_byte_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit)
  );

  function automatic logic [7:0] mfun(input logic [15:0] a);
    return (a[7:0] ^ a[15:8]) + 8'h3C;
  endfunction

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    mem_rdata <= mfun(mem_addr);
    if (wren_set) n_set++;
    if (wren_clr) n_clr++;
    if (status_wr) n_swr++;
    if (wr_commit) n_cmt++;
    if (so_oe) oe_seen <= 1'b1;
    if (wr_byte_valid) begin
      log_a[n_wb % 8] = wr_addr;
      log_d[n_wb % 8] = wr_data;
      n_wb++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bits(input logic [7:0] tx, input int hi, input int lo, inout logic [7:0] rx);
    for (int i = hi; i >= lo; i--) begin
      if (m3) begin
        sck = 1'b0; si = tx[i]; #(HALF); rx[i] = so; sck = 1'b1; #(HALF);
      end else begin
        si = tx[i]; #(HALF); rx[i] = so; sck = 1'b1; #(HALF); sck = 1'b0;
      end
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    logic [7:0] r;
    r = 8'h00;
    bits(tx, 7, 0, r);
    rx = r;
  endtask

  task automatic sel_on();
    sck = m3; #(HALF); oe_seen = 1'b0; cs_n = 1'b0; #(HALF);
  endtask

  task automatic sel_off();
    #(HALF); cs_n = 1'b1; #(2 * HALF);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [7:0] rx, r;
    logic [15:0] ea;
    int s;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R7: reset and deselected state
    chk("R7 reset oe", so_oe, 0);
    chk("R8 reset pulses", n_set + n_clr + n_swr + n_cmt + n_wb, 0);

    // table of reads: R1 R2 R3 R13
    for (int v = 0; v < NV; v++) begin
      m3 = VT[v].m3;
      sel_on();
      xfer(VT[v].op, rx);
      xfer(VT[v].a[15:8], rx);
      xfer(VT[v].a[7:0], rx);
      for (int k = 0; k < 3; k++) begin
        xfer(8'h00, rx);
        ea = VT[v].a + 16'(k);
        if (VT[v].a > ea) chk("R3 read wrap", rx, mfun(ea));
        else chk("R2 R13 read byte", rx, mfun(ea));
      end
      sel_off();
    end

    // R8 R1: set/clear write enable, bit 3 ignored
    m3 = 1'b0;
    sel_on(); xfer(8'h06, rx); sel_off();
    m3 = 1'b1;
    sel_on(); xfer(8'h0E, rx); sel_off();
    chk("R8 R1 set pulses", n_set, 2);
    sel_on(); xfer(8'h04, rx); sel_off();
    chk("R8 clear pulse", n_clr, 1);

    // R9: status read repeats
    m3 = 1'b0; status_in = 8'hA5;
    sel_on(); xfer(8'h05, rx); xfer(8'h00, rx);
    chk("R9 status byte 0", rx, 8'hA5);
    xfer(8'h00, rx);
    chk("R9 status byte 1", rx, 8'hA5);
    sel_off();

    // R10: status write, trailing byte ignored
    sel_on(); xfer(8'h01, rx); xfer(8'h8C, rx); xfer(8'h33, rx); sel_off();
    chk("R10 status write count", n_swr, 1);
    chk("R10 status write data", status_wdata, 8'h8C);

    // R11 R12: write across page end
    m3 = 1'b1;
    sel_on(); xfer(8'h02, rx); xfer(8'h12, rx); xfer(8'h7E, rx);
    xfer(8'h11, rx); xfer(8'h22, rx); xfer(8'h33, rx); sel_off();
    chk("R11 byte count", n_wb, 3);
    chk("R11 addr 0", log_a[0], 16'h127E);
    chk("R11 addr 1", log_a[1], 16'h127F);
    chk("R11 addr page wrap", log_a[2], 16'h1200);
    chk("R11 data 2", log_d[2], 8'h33);
    chk("R12 commit", n_cmt, 1);

    // R7 R12: abort mid byte
    m3 = 1'b0;
    sel_on(); xfer(8'h02, rx); xfer(8'h00, rx); xfer(8'h10, rx);
    r = 8'h00; bits(8'hF0, 7, 4, r); sel_off();
    chk("R12 no commit on partial", n_cmt, 1);
    chk("R7 no byte on partial", n_wb, 3);
    sel_on(); r = 8'h00; bits(8'h06, 7, 4, r); sel_off();
    chk("R7 aborted opcode", n_set, 2);

    // R4: unknown opcode lockout then recovery
    sel_on(); xfer(8'h80, rx); xfer(8'h06, rx); xfer(8'h03, rx); xfer(8'h00, rx);
    sel_off();
    chk("R4 oe stays low", oe_seen, 0);
    chk("R4 no pulse", n_set, 2);
    sel_on(); xfer(8'h06, rx); sel_off();
    chk("R4 recovers", n_set, 3);

    // R5: busy filtering
    busy = 1'b1;
    sel_on(); xfer(8'h06, rx); sel_off();
    chk("R5 wren dropped", n_set, 3);
    sel_on(); xfer(8'h03, rx); xfer(8'h00, rx); xfer(8'h00, rx); xfer(8'h00, rx);
    sel_off();
    chk("R5 read dropped", oe_seen, 0);
    status_in = 8'hFF;
    sel_on(); xfer(8'h05, rx); xfer(8'h00, rx); sel_off();
    chk("R5 status read allowed", rx, 8'hFF);
    busy = 1'b0;

    // R6: pause in the middle of a read byte
    m3 = 1'b0;
    sel_on(); xfer(8'h03, rx); xfer(8'h01, rx); xfer(8'h00, rx);
    r = 8'h00; bits(8'h00, 7, 5, r);
    hold_n = 1'b0; #(HALF);
    s = so_oe;
    chk("R6 oe low in hold", s, 0);
    si = 1'b1; sck = 1'b1; #(HALF); sck = 1'b0; #(HALF);
    sck = 1'b1; #(HALF); sck = 1'b0; #(HALF);
    hold_n = 1'b1; #(HALF);
    bits(8'h00, 4, 0, r);
    chk("R6 byte across hold", r, mfun(16'h0100));
    xfer(8'h00, rx);
    chk("R6 next byte", rx, mfun(16'h0101));
    sel_off();
    chk("R7 oe low after deselect", so_oe, 0);

    summary();
  end
endmodule